// File: doc/BRIEF.md
# Timestamp capture flag logic

This block records the moment an event happens. Two sources can cause a capture: an external timestamp strobe, and a set of tamper event lines. The tamper lines only count when the tamper-to-timestamp enable is high. Each event line is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector, so a line held high yields one event.

When an event arrives, the block raises a pending flag and copies the current time and date word into a capture register. Software clears the pending flag by writing 0 to its bit. If an event lands while the flag is still pending, or in the same cycle as that clear, the block raises a separate overflow flag. No event is lost in either case.

The capture register is a plain register read with no handshake, so there is no back-pressure. The capture holds until software clears the pending flag. An interrupt line follows the pending flag, gated by an enable.

Top module: `ts_capture_top`

## Requirements
- R1: A rising edge on `ts_evt_in` sets `ts_flag` and loads `cap_time` with `cur_time` as sampled at the clock edge where the flag sets. That edge is the third rising clock edge at which the input is sampled high.
- R2: If an event reaches the flag logic in the same cycle as a write with `wr_en`=1 and `wr_flag`=0, both `ts_flag` and `ts_ovf` are 1 afterwards.
- R3: A write with `wr_en`=1 and `wr_flag`=0, with no coincident event, clears `ts_flag`. A write with `wr_flag`=1 leaves it unchanged.
- R4: An event that arrives while `ts_flag` is 1 sets `ts_ovf` and leaves `cap_time` unchanged.
- R5: A write with `wr_en`=1 and `wr_ovf`=0 clears `ts_ovf` when no overflow condition coincides. This write does not change `ts_flag`, and a write with `wr_ovf`=1 leaves `ts_ovf` unchanged.
- R6: An event input that is held high produces exactly one event. Only a low-to-high transition counts.
- R7: A rising edge on any bit of `tamp_evt_in` records a timestamp exactly as in R1 when `tamp_ts_en` is 1. When `tamp_ts_en` is 0 it has no effect on `ts_flag`, `ts_ovf` or `cap_time`.
- R8: `ts_irq` is 1 exactly when `ts_flag` is 1 and `ts_irq_en` is 1, in the same cycle.
- R9: While `rst_n` is low, `ts_flag`, `ts_ovf`, `ts_irq` and `cap_time` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | TIME_W | Current time and date word |
| ts_evt_in | input | 1 | External timestamp event, asynchronous level |
| tamp_evt_in | input | N_TAMP | Tamper event lines, asynchronous levels |
| tamp_ts_en | input | 1 | Lets tamper events record a timestamp |
| ts_irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Flag write strobe |
| wr_flag | input | 1 | Write data for the pending flag (0 clears) |
| wr_ovf | input | 1 | Write data for the overflow flag (0 clears) |
| ts_flag | output | 1 | Timestamp pending flag |
| ts_ovf | output | 1 | Timestamp overflow flag |
| cap_time | output | TIME_W | Captured time and date |
| ts_irq | output | 1 | Interrupt request |

## Verification
An input edge is sampled at clock edge k. It shows up on `ts_flag`, `ts_ovf` and `cap_time` after edge k+2. A flag write takes effect after the edge that samples it, and `ts_irq` follows `ts_flag` and `ts_irq_en` with no delay. The bench drives inputs on falling edges. A behavioural model keeps a history queue of sampled inputs and updates on every rising edge. All four outputs are compared with the model on every falling edge, so each result is checked in the cycle it is due. The stimulus lines up a clear with an event arriving at the same edge. It also covers back-to-back events, a held level, and tamper captures with the enable both off and on.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic pend;
    logic ovf;
  } ts_flags_t;
endpackage

// File: rtl/ts_edge_sync.sv
module ts_edge_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = ts_pkg::SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[LAST];
  end

  assign rise = stg[LAST] & ~prev_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & $past(rise)) == '0)); // R6
endmodule

// File: rtl/ts_evt_merge.sv
module ts_evt_merge #(
  parameter int unsigned N_TAMP = 3
) (
  input  logic              ext_rise,
  input  logic [N_TAMP-1:0] tamp_rise,
  input  logic              tamp_ts_en,
  output logic              evt
);
  logic any_tamp;

  assign any_tamp = |tamp_rise;
  assign evt      = ext_rise | (tamp_ts_en & any_tamp);
endmodule

// File: rtl/ts_flag_ctrl.sv
module ts_flag_ctrl #(
  parameter int unsigned TIME_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic              wr_ovf,
  output logic              ts_flag,
  output logic              ts_ovf,
  output logic [TIME_W-1:0] cap_time
);
  import ts_pkg::*;

  ts_flags_t         fl_q, fl_d;
  logic [TIME_W-1:0] cap_q;
  logic              clr_pend, clr_ovf, load_cap;

  assign clr_pend = wr_en & ~wr_flag;
  assign clr_ovf  = wr_en & ~wr_ovf;
  assign load_cap = evt & ~fl_q.pend;

  always_comb begin
    fl_d = fl_q;
    if (evt)           fl_d.pend = 1'b1;
    else if (clr_pend) fl_d.pend = 1'b0;
    if (evt && (fl_q.pend || clr_pend)) fl_d.ovf = 1'b1;
    else if (clr_ovf)                   fl_d.ovf = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      cap_q <= '0;
    end else begin
      fl_q <= fl_d;
      if (load_cap) cap_q <= cur_time;
    end
  end

  assign ts_flag  = fl_q.pend;
  assign ts_ovf   = fl_q.ovf;
  assign cap_time = cap_q;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> ts_flag); // R1
  AST_CLR_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && wr_en && !wr_flag) |=> (ts_flag && ts_ovf)); // R2
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_flag && !evt) |=> !ts_flag); // R3
  AST_OVF_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ts_flag) |=> ts_ovf); // R4
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ts_flag |=> $stable(cap_time)); // R4
  AST_OVF_CLEAR_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_flag && !evt) |=> (ts_flag == $past(ts_flag))); // R5
endmodule

// File: rtl/ts_capture_top.sv
module ts_capture_top #(
  parameter int unsigned TIME_W = 48,
  parameter int unsigned N_TAMP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              ts_evt_in,
  input  logic [N_TAMP-1:0] tamp_evt_in,
  input  logic              tamp_ts_en,
  input  logic              ts_irq_en,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic              wr_ovf,
  output logic              ts_flag,
  output logic              ts_ovf,
  output logic [TIME_W-1:0] cap_time,
  output logic              ts_irq
);
  localparam int unsigned NLINES = N_TAMP + 1;

  logic [NLINES-1:0] rise_all;
  logic              evt;

  ts_edge_sync #(.W(NLINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({tamp_evt_in, ts_evt_in}),
    .rise (rise_all)
  );

  ts_evt_merge #(.N_TAMP(N_TAMP)) u_merge (
    .ext_rise  (rise_all[0]),
    .tamp_rise (rise_all[NLINES-1:1]),
    .tamp_ts_en(tamp_ts_en),
    .evt       (evt)
  );

  ts_flag_ctrl #(.TIME_W(TIME_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .cur_time(cur_time),
    .wr_en   (wr_en),
    .wr_flag (wr_flag),
    .wr_ovf  (wr_ovf),
    .ts_flag (ts_flag),
    .ts_ovf  (ts_ovf),
    .cap_time(cap_time)
  );

  assign ts_irq = ts_flag & ts_irq_en;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ts_irq |-> ts_flag); // R8
endmodule

// File: tb/ts_capture_top_tb.sv
module ts_capture_top_tb;
  localparam int TW = 48;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cur_time = '0;
  logic          ts_evt_in = 1'b0;
  logic [NT-1:0] tamp_evt_in = '0;
  logic          tamp_ts_en = 1'b0;
  logic          ts_irq_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_flag = 1'b1;
  logic          wr_ovf = 1'b1;
  logic          ts_flag, ts_ovf, ts_irq;
  logic [TW-1:0] cap_time;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  string cur_req = "R9";

  // model state
  bit            m_flag = 0, m_ovf = 0;
  logic [TW-1:0] m_cap = '0;
  bit            ext_q[$];
  logic [NT-1:0] tmp_q[$];

  ts_capture_top #(.TIME_W(TW), .N_TAMP(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .ts_evt_in(ts_evt_in),
    .tamp_evt_in(tamp_evt_in), .tamp_ts_en(tamp_ts_en), .ts_irq_en(ts_irq_en),
    .wr_en(wr_en), .wr_flag(wr_flag), .wr_ovf(wr_ovf),
    .ts_flag(ts_flag), .ts_ovf(ts_ovf), .cap_time(cap_time), .ts_irq(ts_irq)
  );

  always #5 clk = ~clk;

  // Behavioural model: an edge seen at sample m-2 (low at m-3) acts at edge m.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_ovf = 0; m_cap = '0;
      ext_q = {1'b0, 1'b0, 1'b0};
      tmp_q = {3'b000, 3'b000, 3'b000};
    end else begin
      bit ev_e, ev_t, ev, clr_p, clr_o;
      ev_e  = ext_q[$-1] && !ext_q[$-2];
      ev_t  = |(tmp_q[$-1] & ~tmp_q[$-2]);
      ev    = ev_e || (tamp_ts_en && ev_t);
      clr_p = wr_en && !wr_flag;
      clr_o = wr_en && !wr_ovf;
      if (ev && (m_flag || clr_p)) m_ovf = 1;
      else if (clr_o)              m_ovf = 0;
      if (ev && !m_flag) m_cap = cur_time;
      if (ev)         m_flag = 1;
      else if (clr_p) m_flag = 0;
      ext_q.push_back(ts_evt_in);
      tmp_q.push_back(tamp_evt_in);
      if (ext_q.size() > 4) void'(ext_q.pop_front());
      if (tmp_q.size() > 4) void'(tmp_q.pop_front());
    end
  end

  task automatic chk(string what, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", cur_req, what, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk("ts_flag", TW'(ts_flag), TW'(m_flag));
      chk("ts_ovf", TW'(ts_ovf), TW'(m_ovf));
      chk("cap_time", cap_time, m_cap);
      chk("ts_irq", TW'(ts_irq), TW'(m_flag && ts_irq_en)); // R8
      cur_time <= cur_time + 48'h0001_0000_0203;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit f, bit o);
    @(negedge clk); wr_en = 1; wr_flag = f; wr_ovf = o;
    @(negedge clk); wr_en = 0; wr_flag = 1; wr_ovf = 1;
  endtask

  task automatic clear_all();
    wr(0, 0); cyc(1);
  endtask

  initial begin
    cyc(3);
    chk("reset ts_flag R9", TW'(ts_flag), '0);
    chk("reset cap_time R9", cap_time, '0);
    @(negedge clk); rst_n = 1;
    cyc(2);

    // R1 and R6: held-high external event, one capture only
    cur_req = "R1";
    @(negedge clk); ts_evt_in = 1;
    cyc(4);
    chk("flag set R1", TW'(ts_flag), TW'(1));
    cur_req = "R6";
    cyc(6);
    chk("no overflow from held level R6", TW'(ts_ovf), '0);
    @(negedge clk); ts_evt_in = 0;
    cyc(3);

    // R8: interrupt follows enable
    cur_req = "R8";
    @(negedge clk); ts_irq_en = 1; cyc(2);
    @(negedge clk); ts_irq_en = 0; cyc(2);
    ts_irq_en = 1;

    // R3: write 1 no effect, write 0 clears
    cur_req = "R3";
    wr(1, 1); cyc(2);
    chk("flag kept R3", TW'(ts_flag), TW'(1));
    wr(0, 1); cyc(1);
    chk("flag cleared R3", TW'(ts_flag), '0);

    // R4: back-to-back events, second is overflow, capture kept
    cur_req = "R4";
    @(negedge clk); ts_evt_in = 1;
    @(negedge clk); ts_evt_in = 0;
    @(negedge clk); ts_evt_in = 1;
    @(negedge clk); ts_evt_in = 0;
    cyc(4);
    chk("overflow R4", TW'(ts_ovf), TW'(1));

    // R5: clear overflow only, flag untouched
    cur_req = "R5";
    wr(1, 0); cyc(1);
    chk("ovf cleared R5", TW'(ts_ovf), '0);
    chk("flag kept R5", TW'(ts_flag), TW'(1));
    wr(0, 1); cyc(2);

    // R2: clear lands in the same cycle the event reaches the flags
    cur_req = "R2";
    @(negedge clk); ts_evt_in = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; wr_flag = 0; wr_ovf = 1;
    @(negedge clk); wr_en = 0; wr_flag = 1;
    chk("flag after clear+event R2", TW'(ts_flag), TW'(1));
    chk("ovf after clear+event R2", TW'(ts_ovf), TW'(1));
    @(negedge clk); ts_evt_in = 0;
    clear_all(); cyc(2);

    // R7: tamper ignored when disabled, captured when enabled
    cur_req = "R7";
    @(negedge clk); tamp_evt_in = 3'b010;
    cyc(5);
    chk("tamper ignored R7", TW'(ts_flag), '0);
    @(negedge clk); tamp_evt_in = 3'b000; cyc(3);
    @(negedge clk); tamp_ts_en = 1; tamp_evt_in = 3'b100;
    cyc(5);
    chk("tamper capture R7", TW'(ts_flag), TW'(1));
    @(negedge clk); tamp_evt_in = 3'b101; cyc(5);
    @(negedge clk); tamp_evt_in = 3'b000; cyc(3);
    clear_all(); cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule